// File: doc/BRIEF.md
# Expansion RAM and Work-RAM Window Controller

This block serves the CPU address range 0x5000–0x7FFF of a cartridge memory controller. A 4 KiB on-chip expansion RAM answers at 0x5000–0x5FFF. The 8 KiB range at 0x6000–0x7FFF is a window onto a 32 KiB external work RAM. A mode byte selects which 8 KiB page the window shows. The CPU writes that byte through the odd register at 0xA000–0xBFFF. For most mode values no page is selected, and the window is handed back to the program bank map, which lies outside this block.

Two mode values arm a protection capture path. While one of them is active, CPU writes to three fixed expansion addresses are also copied into holding registers, and a flag is set. While the flag is set, reads of three fixed window addresses return the copied bytes instead of window data. Reading the last of the three clears the flag. A separate decode requests that the program bank mapper point all four program windows at bank 0.

Read data and the read select are registered. Both appear one clock after the read strobe. Outside the controlled range, and for a window that is handed back, the block drives neither data nor select, so a bus mux further out can supply the byte.

Top module: `xwin_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the mode byte is 0x00, no page is selected, the capture flag is clear, all three holding registers read 0x00, `cpu_rsel` is 0 and `prg_zero_req` is 0.
- R2: A write with `cpu_addr` in 0x5000–0x5FFF stores the byte in the expansion RAM at index `cpu_addr[11:0]`. A read there returns that byte on `cpu_rdata`, with `cpu_rsel`=1, one cycle after the strobe.
- R3: If the mode byte has upper nibble 0xE and bit 2 set (0xE4–0xE7, 0xEC–0xEF), accesses to 0x6000–0x7FFF go to work-RAM address {mode[1:0], cpu_addr[12:0]}. So 0xE4/0xEC select offset 0x0000, 0xE5/0xED select 0x2000, 0xE6/0xEE select 0x4000 and 0xE7/0xEF select 0x6000. Read data returns one cycle after the strobe, with `cpu_rsel`=1.
- R4: For any other mode value, a window access asserts `bank_win_sel` and neither `wram_we` nor `wram_re`. A window read then gives `cpu_rsel`=0 and `cpu_rdata`=0x00.
- R5: If the mode is 0xA5 or 0xA9, any write in 0x5000–0x5FFF sets the capture flag. Writes to 0x5000, 0x5010 and 0x5013 also load holding registers 0, 1 and 2, in the same cycle as the expansion RAM write, which still occurs.
- R6: While the flag is set, reads of 0x6000, 0x6010 and 0x6013 return holding registers 0, 1 and 2, with `cpu_rsel`=1. These reads take priority over the work-RAM page and over the bank map. Other window addresses behave normally.
- R7: A read of 0x6013 while the flag is set clears it. Later reads of 0x6000, 0x6010 and 0x6013 take the normal window path until the flag is set again.
- R8: A write of 0x02 to 0x5FF3 raises `prg_zero_req` for exactly the following cycle. Any other value, or any other address, leaves it low.
- R9: The mode byte is loaded by writes with `cpu_addr[15:13]`=3'b101 and `cpu_addr[0]`=1. A write with `cpu_addr[0]`=0 in that range leaves the mode unchanged.
- R10: A read outside 0x5000–0x7FFF gives `cpu_rsel`=0 and `cpu_rdata`=0x00 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | One-cycle read strobe |
| cpu_wr | input | 1 | One-cycle write strobe |
| cpu_rdata | output | 8 | Read data, valid the cycle after `cpu_rd` |
| cpu_rsel | output | 1 | Block drives `cpu_rdata` this cycle |
| wram_addr | output | 15 | External work-RAM address |
| wram_wdata | output | 8 | External work-RAM write data |
| wram_we | output | 1 | External work-RAM write enable |
| wram_re | output | 1 | External work-RAM read enable |
| wram_rdata | input | 8 | External work-RAM data, one cycle after `wram_re` |
| bank_win_sel | output | 1 | Window access handed to the program bank map |
| prg_zero_req | output | 1 | Request to force all program windows to bank 0 |

## Verification
The bench targets the order inside the capture path. It reads a captured address while a work-RAM page is selected, to check that the capture wins; a design with the priority reversed returns page data. It reads 0x6013 and then re-reads 0x6000, to check that the flag clears exactly once; a design that never clears keeps returning stale bytes, and one that clears on any hit loses the remaining captures. It uses both codes of every page pair, an even-address write in the mode register range, and writes of 0x02 to addresses next to 0x5FF3. A decode that drops a bit aliases pages, takes the wrong mode or fires the bank-0 request falsely.

// File: rtl/xwin_pkg.sv
// Package: shared types and constants of the expansion/work-RAM window controller.
// Assumes a 16-bit CPU address and 8-bit data.
package xwin_pkg;

    // Source of the registered read data
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_XRAM = 2'd1,
        SRC_WRAM = 2'd2,
        SRC_CAP  = 2'd3
    } rd_src_e;

    localparam int          NSLOT        = 3;
    localparam logic [7:0]  MODE_CAP_A   = 8'hA5;
    localparam logic [7:0]  MODE_CAP_B   = 8'hA9;
    localparam logic [15:0] ADDR_PRGZERO = 16'h5FF3;
    localparam logic [7:0]  VAL_PRGZERO  = 8'h02;

    // Low-byte offset of capture slot i (same offset in 0x5000 and 0x6000 pages)
    function automatic logic [7:0] slot_ofs(input int i);
        case (i)
            0:       return 8'h00;
            1:       return 8'h10;
            default: return 8'h13;
        endcase
    endfunction

endpackage

// File: rtl/xwin_mode_dec.sv
// Module: decodes the mode byte into a work-RAM page select and a capture-arm mode.
// Assumes PAGE_W = 2 (four 8 KiB pages); purely combinational.
module xwin_mode_dec
    import xwin_pkg::*;
#(
    parameter int PAGE_W = 2
) (
    input  logic [7:0]        mode,
    output logic              paged,
    output logic [PAGE_W-1:0] page,
    output logic              cap_mode
);

    // Page codes: upper nibble 0xE with bit 2 set; bit 3 is don't-care
    always_comb begin
        paged    = (mode[7:4] == 4'hE) && mode[2];
        page     = mode[PAGE_W-1:0];
        cap_mode = (mode == MODE_CAP_A) || (mode == MODE_CAP_B);
    end

endmodule

// File: rtl/xwin_xram.sv
// Module: single-port synchronous expansion RAM with a registered read port.
// Assumes read and write strobes are never high together; contents are not reset.
module xwin_xram #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store write data
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Register read data
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (re) q <= mem[addr];
    end

endmodule

// File: rtl/xwin_capture.sv
// Module: protection capture path. Copies writes to fixed expansion offsets into
// holding registers while capture mode is active, and plays them back on reads of
// the matching window offsets until the last slot is read.
// Assumes cap_en and rd_win are never high together.
module xwin_capture
    import xwin_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [11:0]   wr_ofs,
    input  logic [DW-1:0] wdata,
    input  logic          rd_win,
    input  logic [12:0]   rd_ofs,
    output logic          armed,
    output logic          hit,
    output logic [DW-1:0] hit_data
);

    logic [DW-1:0]    held [NSLOT];
    logic [NSLOT-1:0] wr_match;
    logic [NSLOT-1:0] rd_match;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        assign wr_match[i] = cap_en && (wr_ofs == {4'h0, slot_ofs(i)});
        assign rd_match[i] = rd_win && armed && (rd_ofs == {5'h0, slot_ofs(i)});

        // Load holding register on a matching capture write
        always_ff @(posedge clk) begin
            if (!rst_n)           held[i] <= '0;
            else if (wr_match[i]) held[i] <= wdata;
        end

        // R5: holding register changes only on a capture write
        p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !cap_en |=> $stable(held[i]));
    end

    // Arm on any capture-mode expansion write, disarm on reading the last slot
    always_ff @(posedge clk) begin
        if (!rst_n)                 armed <= 1'b0;
        else if (cap_en)            armed <= 1'b1;
        else if (rd_match[NSLOT-1]) armed <= 1'b0;
    end

    // Select the held byte of the matching slot
    always_comb begin
        hit      = |rd_match;
        hit_data = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (rd_match[i]) hit_data = held[i];
        end
    end

    // R7: reading the final slot while armed disarms
    p_arm_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_win && armed && rd_ofs == 13'h0013) |=> !armed);

    // R6: at most one slot matches a read
    p_one_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_match));

endmodule

// File: rtl/xwin_ctrl.sv
// Module: top of the 0x5000-0x7FFF controller. Decodes the CPU address, holds the
// mode byte, drives the external work-RAM port, and muxes registered read data.
// Assumes one CPU access per cycle (cpu_rd and cpu_wr exclusive) and an external
// work RAM that returns data one cycle after wram_re.
module xwin_ctrl
    import xwin_pkg::*;
#(
    parameter int XRAM_AW = 12,
    parameter int PAGE_W  = 2,
    parameter int WIN_AW  = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [15:0]              cpu_addr,
    input  logic [7:0]               cpu_wdata,
    input  logic                     cpu_rd,
    input  logic                     cpu_wr,
    output logic [7:0]               cpu_rdata,
    output logic                     cpu_rsel,
    output logic [PAGE_W+WIN_AW-1:0] wram_addr,
    output logic [7:0]               wram_wdata,
    output logic                     wram_we,
    output logic                     wram_re,
    input  logic [7:0]               wram_rdata,
    output logic                     bank_win_sel,
    output logic                     prg_zero_req
);

    logic              in_xram, in_win, mode_wr, zero_wr;
    logic [7:0]        mode_q;
    logic              paged, cap_mode;
    logic [PAGE_W-1:0] page;
    logic              armed, cap_hit;
    logic [7:0]        cap_data, cap_q, xram_q;
    rd_src_e           src_q;

    // Region and register decode
    always_comb begin
        in_xram = (cpu_addr[15:12] == 4'h5);
        in_win  = (cpu_addr[15:13] == 3'b011);
        mode_wr = cpu_wr && (cpu_addr[15:13] == 3'b101) && cpu_addr[0];
        zero_wr = cpu_wr && (cpu_addr == ADDR_PRGZERO) && (cpu_wdata == VAL_PRGZERO);
    end

    // Mode byte register
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= 8'h00;
        else if (mode_wr) mode_q <= cpu_wdata;
    end

    xwin_mode_dec #(.PAGE_W(PAGE_W)) i_mode_dec (
        .mode     (mode_q),
        .paged    (paged),
        .page     (page),
        .cap_mode (cap_mode)
    );

    xwin_xram #(.AW(XRAM_AW), .DW(8)) i_xram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cpu_wr && in_xram),
        .re    (cpu_rd && in_xram),
        .addr  (cpu_addr[XRAM_AW-1:0]),
        .wdata (cpu_wdata),
        .q     (xram_q)
    );

    xwin_capture #(.DW(8)) i_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cpu_wr && in_xram && cap_mode),
        .wr_ofs   (cpu_addr[11:0]),
        .wdata    (cpu_wdata),
        .rd_win   (cpu_rd && in_win),
        .rd_ofs   (cpu_addr[12:0]),
        .armed    (armed),
        .hit      (cap_hit),
        .hit_data (cap_data)
    );

    // External work-RAM port and bank-map handoff
    always_comb begin
        wram_addr    = {page, cpu_addr[WIN_AW-1:0]};
        wram_wdata   = cpu_wdata;
        wram_we      = cpu_wr && in_win && paged;
        wram_re      = cpu_rd && in_win && paged && !cap_hit;
        bank_win_sel = in_win && !paged && (cpu_wr || (cpu_rd && !cap_hit));
    end

    // Record the source of this cycle's read for the next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= SRC_NONE;
            cap_q <= 8'h00;
        end else begin
            src_q <= SRC_NONE;
            if (cpu_rd) begin
                if (in_xram) begin
                    src_q <= SRC_XRAM;
                end else if (in_win && cap_hit) begin
                    src_q <= SRC_CAP;
                    cap_q <= cap_data;
                end else if (in_win && paged) begin
                    src_q <= SRC_WRAM;
                end
            end
        end
    end

    // One-cycle bank-0 request
    always_ff @(posedge clk) begin
        if (!rst_n) prg_zero_req <= 1'b0;
        else        prg_zero_req <= zero_wr;
    end

    // Read data mux
    always_comb begin
        cpu_rsel = (src_q != SRC_NONE);
        case (src_q)
            SRC_XRAM: cpu_rdata = xram_q;
            SRC_WRAM: cpu_rdata = wram_rdata;
            SRC_CAP:  cpu_rdata = cap_q;
            default:  cpu_rdata = 8'h00;
        endcase
    end

    // R2: select is only raised after a read strobe
    p_rsel_after_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |=> !cpu_rsel);

    // R4: a window access goes either to work RAM or to the bank map, never both
    p_win_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wram_we || wram_re, bank_win_sel}));

    // R9: even-address writes in the mode range leave the mode unchanged
    p_mode_even_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'b101 && !cpu_addr[0]) |=> $stable(mode_q));

    // R8: bank-0 request follows a write
    p_zero_after_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        prg_zero_req |-> $past(cpu_wr));

    // R10: reads outside the region stay quiet
    p_outside_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && (cpu_addr[15:12] < 4'h5 || cpu_addr[15])) |=> (!cpu_rsel && cpu_rdata == 8'h00));

endmodule

// File: tb/test_xwin_ctrl.sv
// Bench: behavioural reference model compared with the outputs on every clock.
module test_xwin_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        cpu_rsel;
    logic [14:0] wram_addr;
    logic [7:0]  wram_wdata;
    logic        wram_we, wram_re;
    logic [7:0]  wram_rdata = '0;
    logic        bank_win_sel, prg_zero_req;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req  = "R1";
    bit    cmp_en   = 1'b0;

    always #2.5 clk = ~clk;

    xwin_ctrl i_xwin_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .cpu_rsel(cpu_rsel),
        .wram_addr(wram_addr), .wram_wdata(wram_wdata), .wram_we(wram_we),
        .wram_re(wram_re), .wram_rdata(wram_rdata), .bank_win_sel(bank_win_sel),
        .prg_zero_req(prg_zero_req)
    );

    // External work RAM
    bit [7:0] ext_mem [int];
    always @(posedge clk) begin
        if (wram_we) ext_mem[int'(wram_addr)] = wram_wdata;
        if (wram_re) wram_rdata <= ext_mem[int'(wram_addr)];
    end

    // Reference model state
    bit [7:0] m_x [int];
    bit [7:0] m_w [int];
    bit [7:0] m_mode;
    bit       m_armed;
    bit [7:0] m_cap [3];
    bit       e_rsel, e_zero;
    bit [7:0] e_data;

    function automatic bit m_paged();
        return (m_mode[7:4] == 4'hE) && m_mode[2];
    endfunction

    function automatic int cap_slot(input int ofs);
        if (ofs == 'h00) return 0;
        if (ofs == 'h10) return 1;
        if (ofs == 'h13) return 2;
        return -1;
    endfunction

    always @(posedge clk) begin
        int a;
        a = int'(cpu_addr);
        if (!rst_n) begin
            m_mode = 0; m_armed = 0;
            foreach (m_cap[i]) m_cap[i] = 0;
            e_rsel = 0; e_data = 0; e_zero = 0;
        end else begin
            e_rsel = 0; e_data = 0; e_zero = 0;
            if (cpu_wr) begin
                if (a >= 'h5000 && a <= 'h5FFF) begin
                    m_x[a - 'h4000] = cpu_wdata;
                    if (m_mode == 8'hA5 || m_mode == 8'hA9) begin
                        m_armed = 1;
                        if (cap_slot(a - 'h5000) >= 0) m_cap[cap_slot(a - 'h5000)] = cpu_wdata;
                    end
                    if (a == 'h5FF3 && cpu_wdata == 8'h02) e_zero = 1;
                end
                if (a >= 'h6000 && a <= 'h7FFF && m_paged())
                    m_w[int'(m_mode[1:0]) * 'h2000 + (a - 'h6000)] = cpu_wdata;
                if ((a & 'hE001) == 'hA001) m_mode = cpu_wdata;
            end
            if (cpu_rd) begin
                if (a >= 'h5000 && a <= 'h5FFF) begin
                    e_rsel = 1; e_data = m_x[a - 'h4000];
                end else if (a >= 'h6000 && a <= 'h7FFF) begin
                    if (m_armed && cap_slot(a - 'h6000) >= 0) begin
                        e_rsel = 1; e_data = m_cap[cap_slot(a - 'h6000)];
                        if (a == 'h6013) m_armed = 0;
                    end else if (m_paged()) begin
                        e_rsel = 1; e_data = m_w[int'(m_mode[1:0]) * 'h2000 + (a - 'h6000)];
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            check(cpu_rsel === e_rsel, cur_req, "cpu_rsel", int'(cpu_rsel), int'(e_rsel));
            check(cpu_rdata === e_data, cur_req, "cpu_rdata", int'(cpu_rdata), int'(e_data));
            check(prg_zero_req === e_zero, cur_req, "prg_zero_req", int'(prg_zero_req), int'(e_zero));
        end
    end

    // One access, held for one cycle
    task automatic op(input bit rd, input bit wr, input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    endtask
    task automatic wr(input logic [15:0] a, input logic [7:0] d); op(0, 1, a, d); endtask
    task automatic rd(input logic [15:0] a); op(1, 0, a, 8'h00); endtask
    task automatic idle(); op(0, 0, 16'h0000, 8'h00); endtask

    // Check the combinational window handoff while an access is on the bus
    task automatic peek_win(input string req, input bit e_bank, input bit e_wram);
        #0.5;
        check(bank_win_sel === e_bank, req, "bank_win_sel", int'(bank_win_sel), int'(e_bank));
        check((wram_we | wram_re) === e_wram, req, "wram access", int'(wram_we | wram_re), int'(e_wram));
    endtask

    initial begin
        #200000;
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    localparam logic [7:0] PAGE_CODES [8] = '{8'hE4, 8'hEC, 8'hE5, 8'hED, 8'hE6, 8'hEE, 8'hE7, 8'hEF};

    initial begin
        cmp_en = 1;
        // R1: reset state
        cur_req = "R1";
        repeat (3) idle();
        check(cpu_rsel === 1'b0 && prg_zero_req === 1'b0, "R1", "outputs in reset",
              int'({cpu_rsel, prg_zero_req}), 0);
        op(0, 0, 16'h0000, 8'h00); rst_n = 1;
        rd(16'h6000); peek_win("R1", 1, 0);
        wr(16'hA001, 8'hA5); wr(16'h5005, 8'h5A);   // arms, no slot written
        rd(16'h6000); rd(16'h6010); rd(16'h6013);     // R1: held bytes read 0x00
        // R2: expansion RAM
        cur_req = "R2";
        wr(16'hA001, 8'h00);
        for (int i = 0; i < 64; i++) wr(16'h5000 + 16'(i), 8'(i * 7 + 3));
        wr(16'h5FFF, 8'hC3); wr(16'h5800, 8'h81);
        for (int i = 0; i < 64; i++) rd(16'h5000 + 16'(i));
        rd(16'h5FFF); rd(16'h5800);
        // R9: mode register decode
        cur_req = "R9";
        wr(16'hA000, 8'hE5);
        rd(16'h6000); peek_win("R9", 1, 0);
        wr(16'hBFFF, 8'hE5);
        wr(16'h6000, 8'h9D); rd(16'h6000); peek_win("R9", 0, 1);
        // R3: each page code, both codes of a pair alias
        cur_req = "R3";
        for (int p = 0; p < 8; p += 2) begin
            wr(16'hA001, PAGE_CODES[p]);
            wr(16'h6100, 8'(8'h10 + p)); wr(16'h7FFF, 8'(8'h20 + p));
        end
        for (int p = 0; p < 8; p++) begin
            wr(16'hA001, PAGE_CODES[p]);
            rd(16'h6100); rd(16'h7FFF);
        end
        // R4: unpaged modes hand the window to the bank map
        cur_req = "R4";
        wr(16'hA001, 8'hE0); wr(16'h6100, 8'hFF); peek_win("R4", 1, 0);
        rd(16'h6100); peek_win("R4", 1, 0);
        wr(16'hA001, 8'hE8); rd(16'h6100); peek_win("R4", 1, 0);
        wr(16'hA001, 8'hE4); rd(16'h6100);   // page 0 untouched by the handed-back write
        // R5/R6/R7: capture, priority, one-shot clear
        cur_req = "R5";
        wr(16'hA001, 8'hA9);
        wr(16'h5000, 8'h11); wr(16'h5010, 8'h22); wr(16'h5013, 8'h33); wr(16'h5001, 8'h44);
        rd(16'h5000); rd(16'h5013);
        wr(16'hA001, 8'hE6);
        wr(16'h6000, 8'h77); wr(16'h6010, 8'h78); wr(16'h6013, 8'h79);
        cur_req = "R6";
        rd(16'h6000); peek_win("R6", 0, 0);
        rd(16'h6001); rd(16'h6010);
        cur_req = "R7";
        rd(16'h6013); rd(16'h6000); rd(16'h6010); rd(16'h6013);
        wr(16'hA001, 8'hA5); wr(16'h5010, 8'h5C); wr(16'hA001, 8'h00);
        rd(16'h6010); peek_win("R7", 0, 0);
        rd(16'h6013); rd(16'h6010); peek_win("R7", 1, 0);
        // R8: bank-0 request
        cur_req = "R8";
        wr(16'h5FF3, 8'h02); wr(16'h5FF3, 8'h03); wr(16'h5FF2, 8'h02);
        wr(16'h5FF3, 8'h02); idle(); idle();
        // R10: outside the region
        cur_req = "R10";
        rd(16'h4FFF); rd(16'h8000); rd(16'h0123); rd(16'hFFFF);
        // Mixed traffic
        cur_req = "R3";
        for (int k = 0; k < 600; k++) begin
            int sel;
            sel = $urandom_range(0, 9);
            case (sel)
                0: wr(16'hA001, PAGE_CODES[$urandom_range(0, 7)]);
                1: wr(16'hA001, ($urandom_range(0, 1) != 0) ? 8'hA5 : 8'h3C);
                2: wr(16'h5000 + 16'($urandom_range(0, 63)), 8'($urandom));
                3: rd(16'h5000 + 16'($urandom_range(0, 63)));
                4: wr(16'h6000 + 16'($urandom_range(0, 31)), 8'($urandom));
                5, 6: rd(16'h6000 + 16'($urandom_range(0, 31)));
                7: wr(16'h5FF3, 8'($urandom_range(1, 3)));
                8: rd(16'h9000 + 16'($urandom_range(0, 255)));
                default: wr(16'h5010 + 16'($urandom_range(0, 3)), 8'($urandom));
            endcase
        end
        idle(); idle();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule